// File: doc/BRIEF.md
# Fair Masked Interrupt Dispatcher

The block collects a vector of interrupt status lines, gates them with a mask that software edits one bit at a time, and on request picks one pending source. No source outranks another. A stored search pointer sets where each search begins. After a selection the pointer moves to the position just after the source that won, so every asserted source is reached in turn.

The vector width is a parameter, 32 or 64. A parameter-defined contiguous window of positions can be cascaded. A winner that falls inside that window is reported as an external interrupt, numbered from the bottom of the window. Any other winner is reported as an internal interrupt with its own position. Each dispatch request gets exactly one registered reply one cycle later, even when there is nothing to report.

Top module: `rr_irq_dispatch`

## Requirements
- R1: After reset the mask reads back as all zeros, no reply strobe is raised, and the search pointer is at position 0, so the first search starts at position 0.
- R2: Only positions whose status bit and mask bit are both 1 count as pending. A status bit whose mask bit is 0 is never selected.
- R3: A dispatch request sampled on a rising clock edge raises `disp_done` for exactly one cycle, on the following edge, and the reply fields are valid in that cycle.
- R4: If nothing is pending, the reply has `disp_hit` = 0 and the search pointer is left unchanged.
- R5: The search starts at the pointer and climbs one position at a time, wrapping modulo WIDTH. The first pending position it meets is selected.
- R6: After a selection the pointer holds the selected position plus one, so the next search begins just after the source that was served.
- R7: With CASCADE = 1, a selected position p with EXT_LO <= p <= EXT_HI is reported with `disp_ext` = 1 and `disp_id` = p - EXT_LO. Every other position is reported with `disp_ext` = 0 and `disp_id` = p.
- R8: A set command makes mask bit `mask_set_idx` 1, and a clear command makes mask bit `mask_clr_idx` 0. No other bit changes. The new mask is visible on `mask_q` after the clock edge that takes the command.
- R9: If a set and a clear name the same bit in the same cycle, the bit ends up 0.
- R10: Selecting position WIDTH-1 wraps the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| status_in | input | WIDTH | Raw interrupt status lines |
| mask_set_en | input | 1 | Command to set one mask bit |
| mask_set_idx | input | log2(WIDTH) | Bit to set |
| mask_clr_en | input | 1 | Command to clear one mask bit |
| mask_clr_idx | input | log2(WIDTH) | Bit to clear |
| mask_q | output | WIDTH | Mask readback |
| disp_req | input | 1 | Dispatch request |
| disp_done | output | 1 | One-cycle reply strobe |
| disp_hit | output | 1 | A source was selected |
| disp_ext | output | 1 | The selected source lies in the cascaded window |
| disp_id | output | log2(WIDTH) | Internal position, or external number |

## Verification
The pointer cannot be observed directly, and the hardest case to reach is a search that has to wrap past the top of the vector to find its winner. The stimulus reaches it by serving a low source first and then a higher one, so the pointer sits above every remaining pending bit. It then selects the top position to force the pointer back to 0. Dispatches with nothing pending are placed between these steps, to show that an empty search leaves the pointer where it was. The cascaded window is crossed at both of its edges.

// File: rtl/rr_irq_dispatch.sv
module rr_irq_dispatch #(
  parameter int WIDTH   = 32,
  parameter bit CASCADE = 1'b1,
  parameter int EXT_LO  = 8,
  parameter int EXT_HI  = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [WIDTH-1:0]         status_in,
  input  logic                     mask_set_en,
  input  logic [$clog2(WIDTH)-1:0] mask_set_idx,
  input  logic                     mask_clr_en,
  input  logic [$clog2(WIDTH)-1:0] mask_clr_idx,
  output logic [WIDTH-1:0]         mask_q,
  input  logic                     disp_req,
  output logic                     disp_done,
  output logic                     disp_hit,
  output logic                     disp_ext,
  output logic [$clog2(WIDTH)-1:0] disp_id
);
  localparam int LW = $clog2(WIDTH);
  localparam logic [LW-1:0] LO = LW'(EXT_LO);
  localparam logic [LW-1:0] HI = LW'(EXT_HI);

  logic [WIDTH-1:0] pend, set_vec, clr_vec;
  logic [LW-1:0]    ptr, sel, cand;
  logic             found, in_win;

  assign pend    = status_in & mask_q;
  assign set_vec = mask_set_en ? (WIDTH'(1) << mask_set_idx) : '0;
  assign clr_vec = mask_clr_en ? (WIDTH'(1) << mask_clr_idx) : '0;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    cand  = '0;
    for (int o = WIDTH - 1; o >= 0; o--) begin
      cand = ptr + LW'(o);
      if (pend[cand]) begin
        found = 1'b1;
        sel   = cand;
      end
    end
  end

  assign in_win = CASCADE && (sel >= LO) && (sel <= HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      ptr       <= '0;
      disp_done <= 1'b0;
      disp_hit  <= 1'b0;
      disp_ext  <= 1'b0;
      disp_id   <= '0;
    end else begin
      mask_q    <= (mask_q | set_vec) & ~clr_vec;
      disp_done <= disp_req;
      if (disp_req) begin
        disp_hit <= found;
        disp_ext <= found && in_win;
        disp_id  <= !found ? '0 : (in_win ? sel - LO : sel);
        if (found) ptr <= sel + LW'(1);
      end
    end
  end
endmodule

// File: rtl/rr_irq_dispatch_chk.sv
module rr_irq_dispatch_chk #(
  parameter int WIDTH   = 32,
  parameter int EXT_LO  = 8,
  parameter int EXT_HI  = 11
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [WIDTH-1:0]         status_in,
  input logic                     mask_set_en,
  input logic [$clog2(WIDTH)-1:0] mask_set_idx,
  input logic                     mask_clr_en,
  input logic [$clog2(WIDTH)-1:0] mask_clr_idx,
  input logic [WIDTH-1:0]         mask_q,
  input logic                     disp_req,
  input logic                     disp_done,
  input logic                     disp_hit,
  input logic                     disp_ext,
  input logic [$clog2(WIDTH)-1:0] disp_id
);
  localparam int LW = $clog2(WIDTH);
  logic             armed;
  logic [WIDTH-1:0] pend_prev;
  logic [LW-1:0]    abs_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      pend_prev <= '0;
    end else begin
      armed     <= 1'b1;
      pend_prev <= status_in & mask_q;
    end
  end

  assign abs_idx = disp_ext ? disp_id + LW'(EXT_LO) : disp_id;

  assert_reply_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    disp_req |=> disp_done);
  assert_no_spurious_reply_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !disp_req |=> !disp_done);
  assert_hit_was_pending_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (disp_done && disp_hit) |-> pend_prev[abs_idx]);
  assert_empty_no_hit_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (disp_done && pend_prev == '0) |-> !disp_hit);
  assert_ext_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (disp_done && disp_ext) |-> (disp_hit && disp_id <= LW'(EXT_HI - EXT_LO)));
  assert_mask_idle_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (!mask_set_en && !mask_clr_en) |=> $stable(mask_q));
  assert_mask_single_set_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (mask_set_en && !mask_clr_en) |=>
      (((mask_q ^ $past(mask_q)) & ~(WIDTH'(1) << $past(mask_set_idx))) == '0));
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (mask_set_en && mask_clr_en && mask_set_idx == mask_clr_idx) |=>
      !mask_q[$past(mask_clr_idx)]);
endmodule

bind rr_irq_dispatch rr_irq_dispatch_chk #(.WIDTH(WIDTH), .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)) u_chk (
  .clk(clk), .rst_n(rst_n), .status_in(status_in),
  .mask_set_en(mask_set_en), .mask_set_idx(mask_set_idx),
  .mask_clr_en(mask_clr_en), .mask_clr_idx(mask_clr_idx), .mask_q(mask_q),
  .disp_req(disp_req), .disp_done(disp_done), .disp_hit(disp_hit),
  .disp_ext(disp_ext), .disp_id(disp_id)
);

// File: tb/rr_irq_dispatch_test.sv
module rr_irq_dispatch_test;
  localparam int PERIOD = 10;
  localparam int W  = 32;
  localparam int LW = 5;
  localparam int NV = 13;

  typedef struct packed {
    logic [W-1:0] st;
    logic         hit;
    logic         ext;
    logic [LW-1:0] id;
  } vec_t;

  localparam vec_t TAB [NV] = '{
    '{32'h0000_0000, 1'b0, 1'b0, 5'd0},
    '{32'h0000_0011, 1'b1, 1'b0, 5'd0},
    '{32'h0000_0011, 1'b1, 1'b0, 5'd4},
    '{32'h0000_0011, 1'b1, 1'b0, 5'd0},
    '{32'h8000_0000, 1'b1, 1'b0, 5'd31},
    '{32'h0000_0F00, 1'b1, 1'b1, 5'd0},
    '{32'h0000_0F00, 1'b1, 1'b1, 5'd1},
    '{32'h0000_1800, 1'b1, 1'b1, 5'd3},
    '{32'h0000_1800, 1'b1, 1'b0, 5'd12},
    '{32'h0000_0080, 1'b1, 1'b0, 5'd7},
    '{32'hFFFF_FFFF, 1'b1, 1'b1, 5'd0},
    '{32'h0000_0000, 1'b0, 1'b0, 5'd0},
    '{32'h0000_0201, 1'b1, 1'b1, 5'd1}
  };

  logic clk = 0, rst_n = 0;
  logic [W-1:0] status_in = '0;
  logic mask_set_en = 0, mask_clr_en = 0, disp_req = 0;
  logic [LW-1:0] mask_set_idx = '0, mask_clr_idx = '0;
  logic [W-1:0] mask_q;
  logic disp_done, disp_hit, disp_ext;
  logic [LW-1:0] disp_id;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  rr_irq_dispatch #(.WIDTH(W), .CASCADE(1'b1), .EXT_LO(8), .EXT_HI(11)) uut (
    .clk(clk), .rst_n(rst_n), .status_in(status_in),
    .mask_set_en(mask_set_en), .mask_set_idx(mask_set_idx),
    .mask_clr_en(mask_clr_en), .mask_clr_idx(mask_clr_idx), .mask_q(mask_q),
    .disp_req(disp_req), .disp_done(disp_done), .disp_hit(disp_hit),
    .disp_ext(disp_ext), .disp_id(disp_id)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic dispatch(input logic [W-1:0] s, input logic eh, input logic ee,
                          input logic [LW-1:0] ei, input string req);
    status_in = s; disp_req = 1;
    tick();
    disp_req = 0;
    check(disp_done == 1'b1, req, 64'(disp_done), 64'd1);
    check({disp_hit, disp_ext, disp_id} == {eh, ee, ei}, req,
          64'({disp_hit, disp_ext, disp_id}), 64'({eh, ee, ei}));
    tick();
    check(disp_done == 1'b0, "R3 strobe one cycle", 64'(disp_done), 64'd0);
  endtask

  task automatic mask_cmd(input logic se, input logic [LW-1:0] si,
                          input logic ce, input logic [LW-1:0] ci);
    mask_set_en = se; mask_set_idx = si; mask_clr_en = ce; mask_clr_idx = ci;
    tick();
    mask_set_en = 0; mask_clr_en = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2; tick(); tick();
    rst_n = 1;
    tick();
    check(mask_q == '0, "R1 mask reset", 64'(mask_q), 64'd0);
    check(disp_done == 1'b0, "R1 no strobe", 64'(disp_done), 64'd0);

    dispatch(32'hFFFF_FFFF, 1'b0, 1'b0, 5'd0, "R2 all masked");

    for (int i = 0; i < W; i++) mask_cmd(1'b1, LW'(i), 1'b0, '0);
    check(mask_q == 32'hFFFF_FFFF, "R8 set all", 64'(mask_q), 64'hFFFF_FFFF);

    for (int v = 0; v < NV; v++)
      dispatch(TAB[v].st, TAB[v].hit, TAB[v].ext, TAB[v].id,
               $sformatf("R5 R6 R7 R4 R10 vec %0d", v));

    mask_cmd(1'b0, '0, 1'b1, 5'd9);
    check(mask_q == 32'hFFFF_FDFF, "R8 clear one", 64'(mask_q), 64'hFFFF_FDFF);
    dispatch(32'h0000_0200, 1'b0, 1'b0, 5'd0, "R2 masked bit ignored");

    mask_cmd(1'b1, 5'd3, 1'b1, 5'd3);
    check(mask_q == 32'hFFFF_FDF7, "R9 clear wins", 64'(mask_q), 64'hFFFF_FDF7);

    mask_cmd(1'b1, 5'd9, 1'b1, 5'd20);
    check(mask_q == 32'hFFEF_FFF7, "R8 set and clear differ", 64'(mask_q), 64'hFFEF_FFF7);

    dispatch(32'h0000_0008, 1'b0, 1'b0, 5'd0, "R2 R9 cleared bit ignored");
    dispatch(32'h0000_0401, 1'b1, 1'b1, 5'd2, "R5 R6 from pointer 10");
    dispatch(32'h0000_0401, 1'b1, 1'b0, 5'd0, "R5 wrap search");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule